// File: doc/BRIEF.md
# Scan Test Sequence Controller

This block drives a complete full-scan test of an on-chip circuit whose state flip-flops are stitched into balanced scan chains. After a start request it first exercises the chains themselves by shifting a short repeating pattern through them and checking what emerges at the far end. It then walks a vector memory. Each vector's state part is shifted into the chains while the primary-input part waits. One normal-mode clock captures the next state. That captured response is shifted out while the next vector's state is shifted in. A final unload brings out the last response.

Every observed bit is compared against expected data held in the same vector word. The block keeps a sticky fail flag and a count of failing vectors, and pulses a done output when the last unload ends. The result stays on the ports until the next start. The vector memory is external and is read through an asynchronous read port addressed by the controller.

Top module: `scan_seq_top`

## Requirements
- R1: After a start is accepted, the block spends CHAIN_LEN+4 cycles in scan mode driving every scan input with the repeating pattern 0,0,1,1 (bit i of the pattern is bit 1 of i), beginning with the cycle after the accepting edge.
- R2: During those cycles, from cycle CHAIN_LEN onward, every scan output is compared with pattern bit (cycle − CHAIN_LEN). A mismatch sets the fail flag but is not counted as a failing vector.
- R3: The vector word is {expected state, expected outputs, stimulus state, stimulus inputs}, with the stimulus inputs in the least significant bits. State bit k·CHAIN_LEN+j belongs to chain k, position j, where position 0 is next to scan-in. Each vector takes CHAIN_LEN shift cycles on all chains in parallel, and the bit for position CHAIN_LEN−1−s is driven in shift cycle s.
- R4: Test control is 1 (scan) in every shift cycle and 0 (normal) in each capture cycle. It comes from a register and changes only at the clock edge that begins a new phase, so it is steady through the whole capture cycle.
- R5: The primary inputs carry the stimulus inputs of the current vector in its capture cycle and are 0 otherwise. The primary outputs are compared with the expected outputs in that cycle only.
- R6: The response captured for vector v is compared at the scan outputs during the shift cycles of vector v+1, position CHAIN_LEN−1−s in shift cycle s. The last vector's response is compared during CHAIN_LEN unload cycles with the scan inputs at 0. The first load is not compared.
- R7: The fail count rises by exactly one for each vector with any output or response mismatch, however many bits differ. The fail flag is set by any mismatch.
- R8: From the accepting edge to the first cycle with done high there are (NUM_VEC+2)·CHAIN_LEN + NUM_VEC + 4 clock edges, and done is high for one cycle.
- R9: A start during a run has no effect. The fail flag and count hold after done and clear at the edge that accepts the next start.
- R10: Out of reset and whenever idle, test control, scan inputs and primary inputs are all 0, done is 0 and the results are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the circuit under test |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a test run, sampled while idle |
| done | output | 1 | One-cycle pulse after the final unload |
| vecAddr | output | AW | Vector memory read address |
| vecData | input | VEC_W | Vector word read at vecAddr |
| testCtrl | output | 1 | Mode select: 1 scan shift, 0 normal capture |
| scanIn | output | NUM_CHAINS | Serial data into each chain |
| priIn | output | PI_W | Primary-input drive to the circuit |
| scanOut | input | NUM_CHAINS | Serial data from the end of each chain |
| priOut | input | PO_W | Primary outputs of the circuit |
| failFlag | output | 1 | Sticky: any mismatch since the last start |
| failCount | output | CW | Number of failing vectors since the last start |

## Verification
A phase counter that is off by one moves the mode select and the serial drive by a cycle. That shows in the first shift or capture cycle after the slip, and the run length at done also changes. A wrong bit-position index or a stale held response gives false fails on a fault-free circuit, at the latest when the first vector's response is unloaded. Bad per-vector accounting shows at done as a fail count that differs from the number of corrupted vectors. That includes corruption of only the first or the last vector, or of both the outputs and the state of one vector.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FLUSH,
    PH_LOAD,
    PH_CAPT,
    PH_UNLOAD,
    PH_DONE
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearAll;    // start accepted: clear results
    logic driveFlush;  // chain test pattern on scan inputs
    logic checkFlush;  // compare chain test pattern at scan outputs
    logic driveLoad;   // vector state bits on scan inputs
    logic checkScan;   // compare held response at scan outputs
    logic capture;     // normal-mode cycle: drive inputs, compare outputs
    logic commitVec;   // last unload bit of a vector: settle its verdict
  } strobe_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NUM_VEC   = 16,
  parameter int CHAIN_LEN = 4,
  parameter int CNT_W     = 3,
  parameter int AW        = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             done,
  output logic             testCtrl,
  output logic [AW-1:0]    vecAddr,
  output logic [CNT_W-1:0] shiftCnt,
  output strobe_t          strb
);

  localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(CHAIN_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_FLUSH = CNT_W'(CHAIN_LEN + 3);
  localparam logic [CNT_W-1:0] FIRST_SEEN = CNT_W'(CHAIN_LEN);
  localparam logic [AW-1:0]    LAST_VEC   = AW'(NUM_VEC - 1);

  phase_e           phase, nxtPh;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic [AW-1:0]    vecIdx, nxtVec;

  always_comb begin
    nxtPh  = phase;
    nxtCnt = cnt;
    nxtVec = vecIdx;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          nxtPh  = PH_FLUSH;
          nxtCnt = '0;
          nxtVec = '0;
        end
      end
      PH_FLUSH: begin
        if (cnt == LAST_FLUSH) begin
          nxtPh  = PH_LOAD;
          nxtCnt = '0;
        end else begin
          nxtCnt = cnt + 1'b1;
        end
      end
      PH_LOAD: begin
        if (cnt == LAST_SHIFT) begin
          nxtPh  = PH_CAPT;
          nxtCnt = '0;
        end else begin
          nxtCnt = cnt + 1'b1;
        end
      end
      PH_CAPT: begin
        nxtCnt = '0;
        if (vecIdx == LAST_VEC) begin
          nxtPh = PH_UNLOAD;
        end else begin
          nxtPh  = PH_LOAD;
          nxtVec = vecIdx + 1'b1;
        end
      end
      PH_UNLOAD: begin
        if (cnt == LAST_SHIFT) begin
          nxtPh  = PH_DONE;
          nxtCnt = '0;
        end else begin
          nxtCnt = cnt + 1'b1;
        end
      end
      PH_DONE:  nxtPh = PH_IDLE;
      default:  nxtPh = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      vecIdx   <= '0;
      testCtrl <= 1'b0;
    end else begin
      phase    <= nxtPh;
      cnt      <= nxtCnt;
      vecIdx   <= nxtVec;
      // mode select is a flop fed from the next phase: no decode glitch
      testCtrl <= (nxtPh == PH_FLUSH) || (nxtPh == PH_LOAD) || (nxtPh == PH_UNLOAD);
    end
  end

  always_comb begin
    strb            = '0;
    strb.clearAll   = (phase == PH_IDLE) && start;
    strb.driveFlush = (phase == PH_FLUSH);
    strb.checkFlush = (phase == PH_FLUSH) && (cnt >= FIRST_SEEN);
    strb.driveLoad  = (phase == PH_LOAD);
    strb.checkScan  = ((phase == PH_LOAD) && (vecIdx != '0)) || (phase == PH_UNLOAD);
    strb.capture    = (phase == PH_CAPT);
    strb.commitVec  = strb.checkScan && (cnt == LAST_SHIFT);
  end

  assign done     = (phase == PH_DONE);
  assign vecAddr  = vecIdx;
  assign shiftCnt = cnt;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_CAPT_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CAPT) |-> !testCtrl); // R4
  AST_MODE_ON_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(testCtrl) |-> !$stable(phase)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !testCtrl); // R10
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    vecIdx <= LAST_VEC); // R3

endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 4,
  parameter int PI_W       = 4,
  parameter int PO_W       = 3,
  parameter int NUM_VEC    = 16,
  parameter int CNT_W      = 3,
  localparam int NUM_SFF   = NUM_CHAINS * CHAIN_LEN,
  localparam int VEC_W     = 2 * NUM_SFF + PI_W + PO_W,
  localparam int CW        = $clog2(NUM_VEC + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [CNT_W-1:0]      shiftCnt,
  input  logic [VEC_W-1:0]      vecData,
  input  logic [NUM_CHAINS-1:0] scanOut,
  input  logic [PO_W-1:0]       priOut,
  output logic [NUM_CHAINS-1:0] scanIn,
  output logic [PI_W-1:0]       priIn,
  output logic                  failFlag,
  output logic [CW-1:0]         failCount
);

  localparam int SEL_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam int ST_LO = PI_W;
  localparam int PO_LO = PI_W + NUM_SFF;
  localparam int EX_LO = PI_W + NUM_SFF + PO_W;

  logic [PI_W-1:0]       stimPi;
  logic [NUM_SFF-1:0]    stimSt;
  logic [PO_W-1:0]       expPo;
  logic [NUM_SFF-1:0]    expSt;
  logic [NUM_SFF-1:0]    expHold;
  logic                  vecBad;
  logic [SEL_W-1:0]      rPos;
  logic [1:0]            flushPh;
  logic                  flushExp;
  logic [NUM_CHAINS-1:0] expOut;
  logic                  scanMis, flushMis, poMis;

  assign stimPi = vecData[0 +: PI_W];
  assign stimSt = vecData[ST_LO +: NUM_SFF];
  assign expPo  = vecData[PO_LO +: PO_W];
  assign expSt  = vecData[EX_LO +: NUM_SFF];

  // shift cycle s serves chain position CHAIN_LEN-1-s on both ends
  assign rPos     = SEL_W'(CHAIN_LEN - 1) - shiftCnt[SEL_W-1:0];
  // pattern index seen at scan-out lags the drive index by CHAIN_LEN
  assign flushPh  = shiftCnt[1:0] - 2'(CHAIN_LEN % 4);
  assign flushExp = (flushPh >= 2'd2);

  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain
    logic [CHAIN_LEN-1:0] ldSlice;
    logic [CHAIN_LEN-1:0] hdSlice;
    assign ldSlice = stimSt[g*CHAIN_LEN +: CHAIN_LEN];
    assign hdSlice = expHold[g*CHAIN_LEN +: CHAIN_LEN];
    always_comb begin
      if (strb.driveFlush)     scanIn[g] = shiftCnt[1];
      else if (strb.driveLoad) scanIn[g] = ldSlice[rPos];
      else                     scanIn[g] = 1'b0;
    end
    assign expOut[g] = strb.checkFlush ? flushExp : hdSlice[rPos];
  end

  assign priIn    = strb.capture ? stimPi : '0;
  assign scanMis  = strb.checkScan && (scanOut != expOut);
  assign flushMis = strb.checkFlush && (scanOut != expOut);
  assign poMis    = strb.capture && (priOut != expPo);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expHold   <= '0;
      vecBad    <= 1'b0;
      failFlag  <= 1'b0;
      failCount <= '0;
    end else if (strb.clearAll) begin
      vecBad    <= 1'b0;
      failFlag  <= 1'b0;
      failCount <= '0;
    end else begin
      if (flushMis || scanMis || poMis) failFlag <= 1'b1;
      if (strb.capture) begin
        expHold <= expSt;
        vecBad  <= poMis;
      end else if (strb.commitVec) begin
        if (vecBad || scanMis) failCount <= failCount + 1'b1;
        vecBad <= 1'b0;
      end else if (scanMis) begin
        vecBad <= 1'b1;
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    failCount <= CW'(NUM_VEC)); // R7
  AST_COUNT_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (failCount != '0) |-> failFlag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strb.clearAll) |=> failFlag); // R9
  AST_PI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |-> (priIn == '0)); // R5

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 4,
  parameter int PI_W       = 4,
  parameter int PO_W       = 3,
  parameter int NUM_VEC    = 16,
  localparam int NUM_SFF   = NUM_CHAINS * CHAIN_LEN,
  localparam int VEC_W     = 2 * NUM_SFF + PI_W + PO_W,
  localparam int AW        = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int CW        = $clog2(NUM_VEC + 1),
  localparam int CNT_W     = $clog2(CHAIN_LEN + 4)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  output logic                  done,
  output logic [AW-1:0]         vecAddr,
  input  logic [VEC_W-1:0]      vecData,
  output logic                  testCtrl,
  output logic [NUM_CHAINS-1:0] scanIn,
  output logic [PI_W-1:0]       priIn,
  input  logic [NUM_CHAINS-1:0] scanOut,
  input  logic [PO_W-1:0]       priOut,
  output logic                  failFlag,
  output logic [CW-1:0]         failCount
);

  strobe_t          strb;
  logic [CNT_W-1:0] shiftCnt;

  scan_seq_ctrl #(
    .NUM_VEC   (NUM_VEC),
    .CHAIN_LEN (CHAIN_LEN),
    .CNT_W     (CNT_W),
    .AW        (AW)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .done     (done),
    .testCtrl (testCtrl),
    .vecAddr  (vecAddr),
    .shiftCnt (shiftCnt),
    .strb     (strb)
  );

  scan_seq_dp #(
    .NUM_CHAINS (NUM_CHAINS),
    .CHAIN_LEN  (CHAIN_LEN),
    .PI_W       (PI_W),
    .PO_W       (PO_W),
    .NUM_VEC    (NUM_VEC),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .shiftCnt  (shiftCnt),
    .vecData   (vecData),
    .scanOut   (scanOut),
    .priOut    (priOut),
    .scanIn    (scanIn),
    .priIn     (priIn),
    .failFlag  (failFlag),
    .failCount (failCount)
  );

endmodule

// File: tb/scan_seq_top_bench.sv
module scan_seq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC    = 2;
  localparam int CL    = 3;
  localparam int NSFF  = NC * CL;
  localparam int PIW   = 3;
  localparam int POW   = 2;
  localparam int NV    = 6;
  localparam int VW    = 2 * NSFF + PIW + POW;
  localparam int AW    = 3;
  localparam int CW    = 3;
  localparam int TOTAL = (NV + 2) * CL + NV + 4;
  localparam int STUCK = 1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic           done;
  logic [AW-1:0]  vecAddr;
  logic [VW-1:0]  vecData;
  logic           testCtrl;
  logic [NC-1:0]  scanIn;
  logic [PIW-1:0] priIn;
  logic [NC-1:0]  scanOut;
  logic [POW-1:0] priOut;
  logic           failFlag;
  logic [CW-1:0]  failCount;

  int nChk = 0;
  int nBad = 0;
  logic stuckOn = 1'b0;

  logic [VW-1:0]   vecMem [NV];
  logic [PIW-1:0]  sPi [NV];
  logic [NSFF-1:0] sSt [NV];
  logic [NSFF-1:0] cutSt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scan_seq_top #(
    .NUM_CHAINS (NC),
    .CHAIN_LEN  (CL),
    .PI_W       (PIW),
    .PO_W       (POW),
    .NUM_VEC    (NV)
  ) u_scan_seq_top (
    .clk (clk), .rstN (rstN), .start (start), .done (done),
    .vecAddr (vecAddr), .vecData (vecData), .testCtrl (testCtrl),
    .scanIn (scanIn), .priIn (priIn), .scanOut (scanOut), .priOut (priOut),
    .failFlag (failFlag), .failCount (failCount)
  );

  function automatic logic [NSFF-1:0] nextFn(logic [PIW-1:0] pi, logic [NSFF-1:0] st);
    return {st[NSFF-2:0], st[NSFF-1]} ^ {pi, pi} ^ ({NSFF{pi[0]}} & {st[0], st[NSFF-1:1]});
  endfunction

  function automatic logic [POW-1:0] poFn(logic [PIW-1:0] pi, logic [NSFF-1:0] st);
    return {(^st) ^ pi[1], (st[0] & pi[2]) | st[NSFF-1]};
  endfunction

  // circuit under test: scan chains plus combinational next-state logic
  always_ff @(posedge clk) begin
    if (testCtrl) begin
      for (int k = 0; k < NC; k++) begin
        cutSt[k*CL] <= scanIn[k];
        for (int j = 1; j < CL; j++) cutSt[k*CL+j] <= cutSt[k*CL+j-1];
      end
    end else begin
      cutSt <= nextFn(priIn, cutSt);
    end
    if (stuckOn) cutSt[STUCK] <= 1'b0;
  end

  always_comb begin
    for (int k = 0; k < NC; k++) scanOut[k] = cutSt[k*CL+CL-1];
  end
  assign priOut  = poFn(priIn, cutSt);
  assign vecData = vecMem[vecAddr];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic buildVectors(bit zero);
    for (int v = 0; v < NV; v++) begin
      sPi[v] = zero ? '0 : PIW'($urandom);
      sSt[v] = zero ? '0 : NSFF'($urandom);
      vecMem[v] = {nextFn(sPi[v], sSt[v]), poFn(sPi[v], sSt[v]), sSt[v], sPi[v]};
    end
  endtask

  task automatic corruptPo(int v);
    vecMem[v][PIW+NSFF] = ~vecMem[v][PIW+NSFF];
  endtask

  task automatic corruptSt(int v, int b);
    vecMem[v][PIW+NSFF+POW+b] = ~vecMem[v][PIW+NSFF+POW+b];
  endtask

  // expected {testCtrl, scanIn, priIn} in run cycle c
  function automatic logic [31:0] expSched(int c);
    logic tc = 1'b1;
    logic [NC-1:0] si = '0;
    logic [PIW-1:0] pi = '0;
    if (c < CL + 4) begin
      si = ((c & 2) != 0) ? '1 : '0;
    end else begin
      int d = c - (CL + 4);
      int v = d / (CL + 1);
      int s = d % (CL + 1);
      if (v < NV) begin
        if (s < CL) begin
          for (int k = 0; k < NC; k++) si[k] = sSt[v][k*CL+CL-1-s];
        end else begin
          tc = 1'b0;
          pi = sPi[v];
        end
      end
    end
    return 32'({tc, si, pi});
  endfunction

  task automatic runTest(string name, int expCnt, bit expFlag, bit chkCnt, int pulseAt);
    int c = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check({"R9 results cleared at start ", name}, 32'({failFlag, failCount}), 32'd0);
    while (!done && c <= TOTAL + 20) begin
      check({"R1 R3 R4 R5 R6 drive schedule ", name},
            32'({testCtrl, scanIn, priIn}), expSched(c));
      start = (c == pulseAt);
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    check({"R8 run length ", name}, 32'(c), 32'(TOTAL));
    check({"R7 fail flag ", name}, 32'(failFlag), 32'(expFlag));
    if (chkCnt) check({"R7 fail count ", name}, 32'(failCount), 32'(expCnt));
    @(negedge clk);
    check({"R8 done single cycle ", name}, 32'(done), 32'd0);
    check({"R10 idle drive ", name}, 32'({testCtrl, scanIn, priIn}), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R10 reset state", 32'({done, testCtrl, scanIn, priIn, failFlag, failCount}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // fault-free run with a start pulse in the middle (R9 ignored)
    buildVectors(1'b0);
    runTest("clean", 0, 1'b0, 1'b1, 10);

    // first vector response, outputs, both at once, and last vector
    buildVectors(1'b0);
    corruptSt(0, 4);
    corruptPo(1);
    corruptSt(3, 0);
    corruptPo(4);
    corruptSt(4, 5);
    corruptSt(5, 2);
    runTest("corrupt", 5, 1'b1, 1'b1, -1);
    repeat (5) @(negedge clk);
    check("R9 results held after done", 32'({failFlag, failCount}), 32'({1'b1, 3'd5}));

    // all-zero vectors: clear on start, no spurious fail
    buildVectors(1'b1);
    runTest("zero", 0, 1'b0, 1'b1, -1);

    // only first vector response wrong: overlapped unload corner (R6)
    buildVectors(1'b0);
    corruptSt(0, 1);
    runTest("first", 1, 1'b1, 1'b1, -1);

    // stuck chain cell: flush test must flag (R2)
    buildVectors(1'b0);
    stuckOn = 1'b1;
    runTest("stuck", 0, 1'b1, 1'b0, -1);
    stuckOn = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule